// File: doc/BRIEF.md
# Narrowing Clamp and Pixel Converter

A single-operation scalar conversion unit. Four of its modes narrow or re-extend integer operands: the operand is read at a source width of 16, 32 or 64 bits and processed at a narrower destination width of 8, 16 or 32 bits. The available operations are plain truncation, saturation, sign-extension and zero-extension. Two further modes repack pixels. One squeezes a 32-bit word holding four 8-bit channels into a 16-bit word with a 1-bit alpha and three 5-bit colour fields. The other expands such a 16-bit word back to four bytes.

The unit handles one operation per strobe and has no internal state beyond its output register. A vector loop, lane selection and any fusing of paired operations are left to the surrounding pipeline. A request is presented with `valid_i`, and the result, its valid flag and an illegal-combination flag appear together one clock later.

Top module: `narrow_pix_unit`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. A result is presented on the clock edge after the strobe. While `rst_ni` is low, `valid_o`, `illegal_o` and `data_o` are 0.
- R2: Mode 0 (chop) returns the low M bits of the operand with all higher result bits 0. Width codes: `src_w_i` 0/1/2 = 16/32/64 bits, `dst_w_i` 0/1/2 = 8/16/32 bits.
- R3: Mode 1 (clamp) with `signed_i`=1 treats the low N bits as two's complement. The result is that value if it fits in M bits, otherwise the most positive or most negative M-bit value. It is given as M bits with higher result bits 0.
- R4: Mode 1 with `signed_i`=0 treats the low N bits as unsigned. The result saturates to all ones in M bits when the value exceeds that.
- R5: Mode 2 (sign-extend) copies bit M-1 of the operand into result bits M..N-1 and keeps bits 0..M-1. Bits above N are 0.
- R6: Mode 3 (zero-extend) keeps operand bits 0..M-1 and clears every other result bit.
- R7: In modes 0 to 3, `illegal_o` is set and `data_o` is 0 when N is not strictly larger than M or when either width code is 3. Modes 6 and 7 are always illegal with a zero result.
- R8: Mode 4 (pack) takes the operand's low 32 bits as bytes A[31:24], R[23:16], G[15:8] and B[7:0]. It returns {A[24], R[23:19], G[15:11], B[7:3]} in bits 15:0, with all other bits 0.
- R9: Mode 5 (unpack) takes bits 15:0 as {a, r5, g5, b5}. It returns {8 copies of a, r5 followed by r5[4:2], g5 followed by g5[4:2], b5 followed by b5[4:2]} in bits 31:0, with all other bits 0.
- R10: While `valid_i` is low, `data_o` and `illegal_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Operation select |
| src_w_i | input | 2 | Source width code |
| dst_w_i | input | 2 | Destination width code |
| signed_i | input | 1 | Signed interpretation for clamp |
| data_i | input | 64 | Operand |
| valid_o | output | 1 | Result valid |
| illegal_o | output | 1 | Illegal mode or width combination |
| data_o | output | 64 | Result |

## Verification
Every result, valid flag and illegal flag is due exactly one rising edge after the strobe that requested it, because the only storage is the output register. The bench drives each request on a falling edge and samples at the next falling edge, which puts exactly one register stage between stimulus and check. Hold behaviour is checked two falling edges after the strobe drops, once new operand values have been applied. Reset is checked while it is still asserted.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned PIX_W  = 32;
  localparam int unsigned HPIX_W = PIX_W / 2;
  localparam int unsigned CH_N   = 3;

  typedef enum logic [2:0] {
    OP_CHOP   = 3'd0,
    OP_CLAMP  = 3'd1,
    OP_SEXT   = 3'd2,
    OP_ZEXT   = 3'd3,
    OP_PACK   = 3'd4,
    OP_UNPACK = 3'd5
  } op_e;

  function automatic logic [6:0] src_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd16;
      2'd1:    return 7'd32;
      2'd2:    return 7'd64;
      default: return 7'd16;
    endcase
  endfunction

  function automatic logic [6:0] dst_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd8;
      2'd1:    return 7'd16;
      2'd2:    return 7'd32;
      default: return 7'd8;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] low_mask(input logic [6:0] bits);
    if (bits >= 7'(DATA_W)) return '1;
    return (DATA_W'(1) << bits) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/npc_narrow.sv
module npc_narrow
  import npc_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [1:0]        src_w_i,
  input  logic [1:0]        dst_w_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o
);
  logic [6:0]        n_bits, m_bits;
  logic [DATA_W-1:0] mask_n, mask_m, sx, zx, max_s, min_s;
  logic              src_neg, fld_neg;

  always_comb begin
    n_bits  = src_bits(src_w_i);
    m_bits  = dst_bits(dst_w_i);
    mask_n  = low_mask(n_bits);
    mask_m  = low_mask(m_bits);
    src_neg = data_i[n_bits-7'd1];
    fld_neg = data_i[m_bits-7'd1];
    zx      = data_i & mask_n;
    sx      = zx | ((signed_i && src_neg) ? ~mask_n : '0);
    max_s   = mask_m >> 1;
    min_s   = ~max_s;
    res_o   = '0;
    case (op_i)
      2'd0: res_o = data_i & mask_m;
      2'd1: begin
        if (signed_i) begin
          if ($signed(sx) > $signed(max_s))      res_o = max_s;
          else if ($signed(sx) < $signed(min_s)) res_o = min_s & mask_m;
          else                                   res_o = sx & mask_m;
        end else begin
          res_o = (zx > mask_m) ? mask_m : zx;
        end
      end
      2'd2: res_o = ((data_i & mask_m) | (fld_neg ? ~mask_m : '0)) & mask_n;
      default: res_o = data_i & mask_m & mask_n;
    endcase
  end
endmodule

// File: rtl/npc_pixel.sv
module npc_pixel
  import npc_pkg::*;
(
  input  logic              unpack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned CW = 5;
  localparam int unsigned BW = PIX_W / 4;

  logic [HPIX_W-1:0] packed_w;
  logic [PIX_W-1:0]  wide_w;

  // alpha: lsb of top byte in, whole top byte out
  assign packed_w[HPIX_W-1]   = data_i[PIX_W-BW];
  assign wide_w[PIX_W-1 -: BW] = {BW{data_i[HPIX_W-1]}};

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    assign packed_w[c*CW +: CW] = data_i[c*BW+BW-1 -: CW];
    assign wide_w[c*BW +: BW]   = {data_i[c*CW +: CW], data_i[c*CW+CW-1 -: BW-CW]};
  end

  always_comb begin
    res_o = '0;
    if (unpack_i) res_o[PIX_W-1:0]  = wide_w;
    else          res_o[HPIX_W-1:0] = packed_w;
  end
endmodule

// File: rtl/narrow_pix_unit.sv
module narrow_pix_unit
  import npc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        src_w_i,
  input  logic [1:0]        dst_w_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] nar_res, pix_res, res_d;
  logic              is_nar, is_pix, ill_d;

  npc_narrow i_narrow (
    .op_i    (mode_i[1:0]),
    .src_w_i (src_w_i),
    .dst_w_i (dst_w_i),
    .signed_i(signed_i),
    .data_i  (data_i),
    .res_o   (nar_res)
  );

  npc_pixel i_pixel (
    .unpack_i(mode_i == OP_UNPACK),
    .data_i  (data_i),
    .res_o   (pix_res)
  );

  always_comb begin
    is_nar = (mode_i[2] == 1'b0);
    is_pix = (mode_i == OP_PACK) || (mode_i == OP_UNPACK);
    if (is_nar)
      ill_d = (src_w_i == 2'd3) || (dst_w_i == 2'd3) || (src_w_i < dst_w_i);
    else
      ill_d = !is_pix;
    if (ill_d)       res_d = '0;
    else if (is_nar) res_d = nar_res;
    else             res_d = pix_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      data_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= ill_d;
        data_o    <= res_d;
      end
    end
  end
endmodule

// File: rtl/npc_checker.sv
module npc_checker
  import npc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        mode_i,
  input logic [1:0]        dst_w_i,
  input logic              signed_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [DATA_W-1:0] data_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R1
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (data_o == '0)); // R7
  AST_UCLAMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd1 && !signed_i && dst_w_i == 2'd0) |=> (data_o[DATA_W-1:8] == '0)); // R4
  AST_PACK_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd4) |=> (data_o[DATA_W-1:HPIX_W] == '0)); // R8
  AST_UNPACK_ALPHA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 3'd5) |=> (data_o[PIX_W-1:PIX_W-8] == 8'h00 || data_o[PIX_W-1:PIX_W-8] == 8'hFF)); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(illegal_o))); // R10
endmodule

bind narrow_pix_unit npc_checker i_npc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .dst_w_i  (dst_w_i),
  .signed_i (signed_i),
  .valid_o  (valid_o),
  .illegal_o(illegal_o),
  .data_o   (data_o)
);

// File: tb/test_narrow_pix_unit.sv
module test_narrow_pix_unit;
  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  sw;
    logic [1:0]  dw;
    logic        sg;
    logic [63:0] din;
    logic [63:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd2, 2'd0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hF0, 1'b0, 4'd2},                 // R2
    '{3'd0, 2'd1, 2'd1, 1'b1, 64'hFFFF_FFFF_8765_4321, 64'h4321, 1'b0, 4'd2},               // R2
    '{3'd1, 2'd1, 2'd0, 1'b1, 64'h0000_0000_0000_0100, 64'h7F, 1'b0, 4'd3},                 // R3
    '{3'd1, 2'd1, 2'd0, 1'b1, 64'h0000_0000_FFFF_FF00, 64'h80, 1'b0, 4'd3},                 // R3
    '{3'd1, 2'd1, 2'd0, 1'b1, 64'hAAAA_AAAA_FFFF_FFC5, 64'hC5, 1'b0, 4'd3},                 // R3
    '{3'd1, 2'd2, 2'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000, 1'b0, 4'd3},          // R3
    '{3'd1, 2'd2, 2'd1, 1'b0, 64'h0000_0000_0001_0000, 64'hFFFF, 1'b0, 4'd4},               // R4
    '{3'd1, 2'd2, 2'd1, 1'b0, 64'h0000_0000_0000_1234, 64'h1234, 1'b0, 4'd4},               // R4
    '{3'd2, 2'd2, 2'd0, 1'b0, 64'h0000_0000_0000_0080, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd5},// R5
    '{3'd2, 2'd1, 2'd1, 1'b0, 64'hDEAD_BEEF_0000_8001, 64'hFFFF_8001, 1'b0, 4'd5},          // R5
    '{3'd2, 2'd1, 2'd0, 1'b0, 64'h0000_0000_0000_007F, 64'h7F, 1'b0, 4'd5},                 // R5
    '{3'd3, 2'd2, 2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF, 1'b0, 4'd6},          // R6
    '{3'd3, 2'd0, 2'd0, 1'b1, 64'h0000_0000_0000_FFFF, 64'hFF, 1'b0, 4'd6},                 // R6
    '{3'd0, 2'd0, 2'd1, 1'b0, 64'h0000_0000_0000_FFFF, 64'h0, 1'b1, 4'd7},                  // R7
    '{3'd1, 2'd1, 2'd2, 1'b1, 64'h0000_0000_8000_0000, 64'h0, 1'b1, 4'd7},                  // R7
    '{3'd6, 2'd2, 2'd0, 1'b0, 64'h0000_0000_0000_00FF, 64'h0, 1'b1, 4'd7},                  // R7
    '{3'd0, 2'd3, 2'd0, 1'b0, 64'h0000_0000_0000_00FF, 64'h0, 1'b1, 4'd7},                  // R7
    '{3'd4, 2'd0, 2'd0, 1'b0, 64'h1111_2222_FFF8_07FF, 64'hFC1F, 1'b0, 4'd8},               // R8
    '{3'd4, 2'd0, 2'd0, 1'b0, 64'h0000_0000_0E84_4221, 64'h4104, 1'b0, 4'd8},               // R8
    '{3'd5, 2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_FC1F, 64'hFFFF_00FF, 1'b0, 4'd9},          // R9
    '{3'd5, 2'd0, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_4104, 64'h0084_4221, 1'b0, 4'd9},          // R9
    '{3'd5, 2'd0, 2'd0, 1'b0, 64'h0000_0000_0000_0001, 64'h0000_0008, 1'b0, 4'd9}           // R9
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  src_w_i = '0;
  logic [1:0]  dst_w_i = '0;
  logic        signed_i = 1'b0;
  logic [63:0] data_i = '0;
  logic        valid_o, illegal_o;
  logic [63:0] data_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  narrow_pix_unit i_narrow_pix_unit (
    .clk_i, .rst_ni, .valid_i, .mode_i, .src_w_i, .dst_w_i,
    .signed_i, .data_i, .valid_o, .illegal_o, .data_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode_i = v.mode; src_w_i = v.sw; dst_w_i = v.dw;
    signed_i = v.sg; data_i = v.din; valid_i = 1'b1;
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, sampled while reset is held
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", 64'(valid_o), 64'd0);
    check("R1 reset data", data_o, 64'd0);
    check("R1 reset illegal", 64'(illegal_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk_i);
      valid_i = 1'b0;
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), data_o, VECS[i].exp);
      check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), 64'(illegal_o), 64'(VECS[i].ill));
      check($sformatf("R1 vec%0d valid", i), 64'(valid_o), 64'd1);
    end

    // R1 valid drops one cycle after strobe drops
    @(negedge clk_i);
    check("R1 valid low", 64'(valid_o), 64'd0);

    // R10 hold: new operand without strobe must not change outputs
    drive(VECS[0]);
    @(negedge clk_i);
    valid_i = 1'b0;
    data_i = 64'hFFFF_FFFF_FFFF_FFFF; mode_i = 3'd6;
    repeat (2) @(negedge clk_i);
    check("R10 hold data", data_o, 64'hF0);
    check("R10 hold illegal", 64'(illegal_o), 64'd0);

    // R7 then R10: illegal flag held after strobe drops
    drive(VECS[13]);
    @(negedge clk_i);
    valid_i = 1'b0; mode_i = 3'd0; src_w_i = 2'd2; dst_w_i = 2'd0;
    repeat (2) @(negedge clk_i);
    check("R10 hold illegal set", 64'(illegal_o), 64'd1);

    // R8 alpha lsb only
    drive('{3'd4, 2'd0, 2'd0, 1'b0, 64'h0100_0000, 64'h8000, 1'b0, 4'd8});
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R8 alpha lsb", data_o, 64'h8000);

    // R1 asynchronous reset mid-run
    drive(VECS[11]);
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    check("R1 async reset valid", 64'(valid_o), 64'd0);
    check("R1 async reset data", data_o, 64'd0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule